// File: doc/BRIEF.md
# Decode-Stage Hazard Interlock for a Multi-Latency In-Order Pipeline

This block sits beside the decode stage of a 32-bit in-order pipeline. It decides each cycle whether the decoded micro-op may move on to register read, and from where each of its operands will come. The front end is fetch, micro-op convert, decode and then register read. After register read, a micro-op takes one of three execution paths. Int-add has one ALU stage. Load and store have an ALU (address) stage followed by four memory stages. FP-add has three FP stages. Every path ends in a shared register-write stage. The register file has unlimited write ports, so the only reason to hold decode is a true read-after-write dependence.

The unit keeps a shift record of in-flight register writers, holding each one's class and destination. One record entry advances per cycle: a bubble goes in when decode is held or idle. A mode input selects either no bypassing or full bypassing.

Without bypassing, a register written in the first half of a cycle can be read in the second half of the same cycle. With bypassing, a result is usable from the end of its last compute stage. Each operand of the consumer is compared against the stage where that operand is actually needed. For a store, the address is needed at the ALU stage and the data only at the first memory stage. Each operand also gets a forwarding select that tells the datapath which in-flight result to pick.

Top module: `hzl_interlock`

## Requirements
- R1: With `in_valid` low, `stall` is 0 and both selects are 0, whatever the record holds. After reset the record is empty.
- R2: With `bypass_en`=0, a consumer issued in the cycle right after its producer stalls as follows. Int-add to int-add: 1 cycle. Load to FP-add: 5 cycles. Load to store address: 5 cycles. FP-add to store data: 3 cycles.
- R3: With `bypass_en`=1, the same adjacent pairs stall as follows. Int-add to int-add: 0. Load to FP-add: 4. Load to store address: 4. FP-add to store data: 1. Load to load address: 4.
- R4: A store's two operands are checked against different need stages. With bypassing, FP-add to store address stalls 2 and int-add to store data stalls 0.
- R5: Each independent micro-op issued between producer and consumer lowers the stall by one, down to 0. With bypassing, load to FP-add with one micro-op between stalls 3. Without bypassing, with two between, it stalls 3. Without bypassing, int-add to store data with one between stalls 0.
- R6: When several in-flight writers target the same register, only the youngest one decides the stall and the select.
- R7: A store writes no register, so it never causes a stall. A load uses only `in_src_a`, and its `in_src_b` is ignored.
- R8: Stage positions count from register read = 0, then one per cycle after leaving decode. In this numbering the ALU is 1 and the first memory stage is 2. With bypassing, an operand that the register-file read would miss gets a select equal to the producer's position in the cycle when the consumer reaches its need stage. Int-add to int-add gives 2. Load to FP-add after its stall gives 6. FP-add to store data gives 4. Int-add to store data gives 3.
- R9: A select of 0 means the register file. The selects are 0 whenever bypassing is off, whenever `stall` is 1, and whenever the producer reaches register write no later than the consumer's register read.
- R10: `stall` never stays high for more than 5 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_en | input | 1 | 1 = full bypassing, 0 = no bypassing |
| in_valid | input | 1 | Decode holds a micro-op |
| in_cls | input | 2 | Class: 0 int-add, 1 load, 2 store, 3 FP-add |
| in_src_a | input | REG_W | First source (the address for load and store) |
| in_src_b | input | REG_W | Second source (the data for a store, unused for a load) |
| in_dst | input | REG_W | Destination (ignored for store) |
| stall | output | 1 | Hold the micro-op in decode this cycle |
| fwd_a | output | FWD_W | Forwarding select for source A |
| fwd_b | output | FWD_W | Forwarding select for source B |

## Verification
The hardest case to reach is a stall that is decided by a younger writer while an older writer of the same register is still in flight. The bench produces it by issuing a load and then an int-add to the same register back to back, followed by a consumer, so that the older load would wrongly demand a long stall. A second hard case is a consumer that changes while it is held in decode. This is reached by swapping the held consumer in the middle of a no-bypass stall and confirming that the total hold still ends on time. The vector table places producer, consumer and gap in exact cycles, and it counts the stall cycles until release.

// File: rtl/hzl_pkg.sv
package hzl_pkg;

   typedef enum logic [1:0] {
      OP_INT = 2'd0,
      OP_LD  = 2'd1,
      OP_ST  = 2'd2,
      OP_FP  = 2'd3
   } op_cls_e;

   // position (register read = 0) of the last compute stage of a writer
   function automatic int done_pos(op_cls_e c, int alu, int mem, int fp);
      case (c)
         OP_INT:  return alu;
         OP_LD:   return alu + mem;
         OP_FP:   return fp;
         default: return 0;
      endcase
   endfunction

   // position of the register-write stage of a writer
   function automatic int wb_pos(op_cls_e c, int alu, int mem, int fp);
      return done_pos(c, alu, mem, fp) + 1;
   endfunction

endpackage

// File: rtl/hzl_slot_pipe.sv
module hzl_slot_pipe
   import hzl_pkg::*;
#(
   parameter int REG_W = 5,
   parameter int DEPTH = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            push,
   input  op_cls_e                         push_cls,
   input  logic [REG_W-1:0]                push_dst,
   output logic [DEPTH-1:0]                slot_vld,
   output op_cls_e                         slot_cls [DEPTH],
   output logic [DEPTH-1:0][REG_W-1:0]     slot_dst
);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot_vld[0] <= 1'b0;
               slot_cls[0] <= OP_INT;
               slot_dst[0] <= '0;
            end else begin
               slot_vld[0] <= push;
               slot_cls[0] <= push_cls;
               slot_dst[0] <= push_dst;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot_vld[i] <= 1'b0;
               slot_cls[i] <= OP_INT;
               slot_dst[i] <= '0;
            end else begin
               slot_vld[i] <= slot_vld[i-1];
               slot_cls[i] <= slot_cls[i-1];
               slot_dst[i] <= slot_dst[i-1];
            end
         end
      end
   end

endmodule

// File: rtl/hzl_opnd_chk.sv
module hzl_opnd_chk
   import hzl_pkg::*;
#(
   parameter int REG_W      = 5,
   parameter int DEPTH      = 5,
   parameter int ALU_STAGES = 1,
   parameter int MEM_STAGES = 4,
   parameter int FP_STAGES  = 3,
   parameter int FWD_W      = 3
) (
   input  logic                        used,
   input  logic [REG_W-1:0]            src,
   input  logic [FWD_W-1:0]            need,
   input  logic                        bypass_en,
   input  logic [DEPTH-1:0]            slot_vld,
   input  op_cls_e                     slot_cls [DEPTH],
   input  logic [DEPTH-1:0][REG_W-1:0] slot_dst,
   output logic                        hold,
   output logic [FWD_W-1:0]            sel
);

   logic    hit;
   int      hit_pos;
   op_cls_e hit_cls;

   // scan oldest to youngest so the youngest match is kept last
   always_comb begin
      hit     = 1'b0;
      hit_pos = 0;
      hit_cls = OP_INT;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (used && slot_vld[i] && (slot_dst[i] == src)) begin
            hit     = 1'b1;
            hit_pos = i;
            hit_cls = slot_cls[i];
         end
      end
   end

   int  wb, dn, n;
   logic rf_miss;

   always_comb begin
      wb      = wb_pos(hit_cls, ALU_STAGES, MEM_STAGES, FP_STAGES);
      dn      = done_pos(hit_cls, ALU_STAGES, MEM_STAGES, FP_STAGES);
      n       = int'(need);
      rf_miss = (hit_pos + 1) < wb;
      hold    = 1'b0;
      sel     = '0;
      if (hit) begin
         if (!bypass_en) begin
            hold = rf_miss;
         end else begin
            hold = (hit_pos + n) < dn;
            if (!hold && rf_miss) sel = FWD_W'(hit_pos + 1 + n);
         end
      end
   end

endmodule

// File: rtl/hzl_interlock.sv
module hzl_interlock
   import hzl_pkg::*;
#(
   parameter int REG_W      = 5,
   parameter int ALU_STAGES = 1,
   parameter int MEM_STAGES = 4,
   parameter int FP_STAGES  = 3,
   parameter int FWD_W      = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bypass_en,
   input  logic             in_valid,
   input  logic [1:0]       in_cls,
   input  logic [REG_W-1:0] in_src_a,
   input  logic [REG_W-1:0] in_src_b,
   input  logic [REG_W-1:0] in_dst,
   output logic             stall,
   output logic [FWD_W-1:0] fwd_a,
   output logic [FWD_W-1:0] fwd_b
);

   localparam int LONG_DONE = (ALU_STAGES + MEM_STAGES > FP_STAGES) ?
                              ALU_STAGES + MEM_STAGES : FP_STAGES;
   localparam int WB_MAX    = LONG_DONE + 1;
   localparam int DEPTH     = WB_MAX - 1;
   localparam int SEL_MAX   = WB_MAX + ALU_STAGES;
   localparam int DATA_NEED = ALU_STAGES + 1;

   if (REG_W < 1) begin : g_bad_reg
      $error("REG_W must be at least 1");
   end
   if (ALU_STAGES < 1 || MEM_STAGES < 1 || FP_STAGES < 1) begin : g_bad_path
      $error("every execution path needs at least one stage");
   end
   if ((1 << FWD_W) <= SEL_MAX) begin : g_bad_fwd
      $error("FWD_W too narrow for the deepest forwarding position");
   end

   op_cls_e cls;
   assign cls = op_cls_e'(in_cls);

   logic [DEPTH-1:0]            slot_vld;
   op_cls_e                     slot_cls [DEPTH];
   logic [DEPTH-1:0][REG_W-1:0] slot_dst;

   hzl_slot_pipe #(.REG_W(REG_W), .DEPTH(DEPTH)) u_slots (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (in_valid && !stall && (cls != OP_ST)),
      .push_cls (cls),
      .push_dst (in_dst),
      .slot_vld (slot_vld),
      .slot_cls (slot_cls),
      .slot_dst (slot_dst)
   );

   logic [1:0]                  op_used;
   logic [1:0][REG_W-1:0]       op_src;
   logic [1:0][FWD_W-1:0]       op_need;
   logic [1:0]                  op_hold;
   logic [1:0][FWD_W-1:0]       op_sel;

   assign op_used = {cls != OP_LD, 1'b1};
   assign op_src  = {in_src_b, in_src_a};
   assign op_need[0] = FWD_W'(1);
   assign op_need[1] = (cls == OP_ST) ? FWD_W'(DATA_NEED) : FWD_W'(1);

   for (genvar k = 0; k < 2; k++) begin : g_opnd
      hzl_opnd_chk #(
         .REG_W(REG_W), .DEPTH(DEPTH), .ALU_STAGES(ALU_STAGES),
         .MEM_STAGES(MEM_STAGES), .FP_STAGES(FP_STAGES), .FWD_W(FWD_W)
      ) u_chk (
         .used      (op_used[k]),
         .src       (op_src[k]),
         .need      (op_need[k]),
         .bypass_en (bypass_en),
         .slot_vld  (slot_vld),
         .slot_cls  (slot_cls),
         .slot_dst  (slot_dst),
         .hold      (op_hold[k]),
         .sel       (op_sel[k])
      );
   end

   assign stall = in_valid && (|op_hold);
   assign fwd_a = (in_valid && !stall) ? op_sel[0] : '0;
   assign fwd_b = (in_valid && !stall) ? op_sel[1] : '0;

endmodule

// File: rtl/hzl_interlock_chk.sv
module hzl_interlock_chk #(
   parameter int REG_W      = 5,
   parameter int ALU_STAGES = 1,
   parameter int MEM_STAGES = 4,
   parameter int FP_STAGES  = 3,
   parameter int FWD_W      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bypass_en,
   input logic             in_valid,
   input logic [1:0]       in_cls,
   input logic [REG_W-1:0] in_src_a,
   input logic [REG_W-1:0] in_src_b,
   input logic [REG_W-1:0] in_dst,
   input logic             stall,
   input logic [FWD_W-1:0] fwd_a,
   input logic [FWD_W-1:0] fwd_b
);

   localparam int LONG_DONE = (ALU_STAGES + MEM_STAGES > FP_STAGES) ?
                              ALU_STAGES + MEM_STAGES : FP_STAGES;
   localparam int MAX_HOLD  = LONG_DONE;

   logic             prev_int;
   logic [REG_W-1:0] prev_dst;
   int               run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_int <= 1'b0;
         prev_dst <= '0;
         run_cnt  <= 0;
      end else begin
         prev_int <= in_valid && !stall && (in_cls == 2'd0);
         prev_dst <= in_dst;
         run_cnt  <= stall ? run_cnt + 1 : 0;
      end
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!stall && fwd_a == '0 && fwd_b == '0));

   a_r9_rf_only_without_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      !bypass_en |-> (fwd_a == '0 && fwd_b == '0));

   a_r9_no_select_while_held: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (fwd_a == '0 && fwd_b == '0));

   a_r2_int_int_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_int && in_valid && in_cls == 2'd0 && in_src_a == prev_dst && !bypass_en)
      |-> stall);

   a_r3_int_int_flows: assert property (@(posedge clk) disable iff (!rst_n)
      (ALU_STAGES == 1 && prev_int && in_valid && in_cls == 2'd0 &&
       in_src_a == prev_dst && bypass_en) |-> !stall);

   a_r10_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (run_cnt < MAX_HOLD));

endmodule

bind hzl_interlock hzl_interlock_chk #(
   .REG_W(REG_W), .ALU_STAGES(ALU_STAGES), .MEM_STAGES(MEM_STAGES),
   .FP_STAGES(FP_STAGES), .FWD_W(FWD_W)
) u_hzl_chk (.*);

// File: tb/hzl_interlock_bench.sv
module hzl_interlock_bench;

   localparam int REG_W = 5;
   localparam int FWD_W = 3;

   localparam logic [1:0] C_INT = 2'd0, C_LD = 2'd1, C_ST = 2'd2, C_FP = 2'd3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bypass_en = 1'b0;
   logic             in_valid = 1'b0;
   logic [1:0]       in_cls = 2'd0;
   logic [REG_W-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
   logic             stall;
   logic [FWD_W-1:0] fwd_a, fwd_b;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   hzl_interlock #(.REG_W(REG_W), .FWD_W(FWD_W)) u_hzl_interlock (
      .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en), .in_valid(in_valid),
      .in_cls(in_cls), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
      .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] c, input int a, input int b, input int d);
      in_valid = 1'b1;
      in_cls   = c;
      in_src_a = REG_W'(a);
      in_src_b = REG_W'(b);
      in_dst   = REG_W'(d);
   endtask

   task automatic drain();
      in_valid = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   // count cycles the current decode micro-op is held; returns at negedge+1
   task automatic count_hold(output int cnt);
      cnt = 0;
      #1;
      while (stall && cnt < 20) begin
         cnt++;
         @(negedge clk);
         #1;
      end
   endtask

   // {mode, producer, consumer, operand(0=a,1=b), gap, stalls, select}
   localparam int NV = 16;
   localparam logic [13:0] VEC [NV] = '{
      {1'b1, C_INT, C_INT, 1'b0, 2'd0, 3'd0, 3'd2},
      {1'b1, C_LD,  C_FP,  1'b0, 2'd0, 3'd4, 3'd6},
      {1'b1, C_LD,  C_ST,  1'b0, 2'd0, 3'd4, 3'd6},
      {1'b1, C_FP,  C_ST,  1'b1, 2'd0, 3'd1, 3'd4},
      {1'b0, C_INT, C_INT, 1'b0, 2'd0, 3'd1, 3'd0},
      {1'b0, C_LD,  C_FP,  1'b0, 2'd0, 3'd5, 3'd0},
      {1'b0, C_LD,  C_ST,  1'b0, 2'd0, 3'd5, 3'd0},
      {1'b0, C_FP,  C_ST,  1'b1, 2'd0, 3'd3, 3'd0},
      {1'b1, C_FP,  C_ST,  1'b0, 2'd0, 3'd2, 3'd4},
      {1'b1, C_INT, C_ST,  1'b1, 2'd0, 3'd0, 3'd3},
      {1'b1, C_LD,  C_FP,  1'b0, 2'd1, 3'd3, 3'd6},
      {1'b0, C_LD,  C_FP,  1'b0, 2'd2, 3'd3, 3'd0},
      {1'b1, C_INT, C_INT, 1'b1, 2'd1, 3'd0, 3'd0},
      {1'b1, C_INT, C_FP,  1'b1, 2'd0, 3'd0, 3'd2},
      {1'b1, C_LD,  C_LD,  1'b0, 2'd0, 3'd4, 3'd6},
      {1'b0, C_INT, C_ST,  1'b1, 2'd1, 3'd0, 3'd0}
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int cnt;
      string tag_s, tag_f;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset stall", int'(stall), 0);
      chk("R1 reset fwd_a", int'(fwd_a), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // ---- table walk ----
      for (int v = 0; v < NV; v++) begin
         logic [13:0] e;
         e = VEC[v];
         drain();
         bypass_en = e[13];
         drive(e[12:11], 1, 2, 5);
         @(negedge clk);
         for (int g = 0; g < int'(e[7:6]); g++) begin
            drive(C_INT, 3, 4, 9);
            @(negedge clk);
         end
         if (e[8]) drive(e[10:9], 6, 5, 10);
         else      drive(e[10:9], 5, 6, 10);
         count_hold(cnt);
         if (e[7:6] != 0)          tag_s = "R5 stall";
         else if (e[10:9] == C_ST) tag_s = "R4 stall";
         else if (e[13])           tag_s = "R3 stall";
         else                      tag_s = "R2 stall";
         tag_f = e[13] ? "R8 select" : "R9 select";
         chk($sformatf("%s vec%0d", tag_s, v), cnt, int'(e[5:3]));
         chk($sformatf("%s vec%0d", tag_f, v), int'(e[8] ? fwd_b : fwd_a), int'(e[2:0]));
         @(negedge clk);
      end

      // ---- R1: dependence present but decode idle ----
      drain();
      bypass_en = 1'b0;
      drive(C_LD, 1, 2, 5);
      @(negedge clk);
      drive(C_INT, 5, 5, 10);
      in_valid = 1'b0;
      #1;
      chk("R1 idle stall", int'(stall), 0);
      chk("R1 idle fwd_a", int'(fwd_a), 0);
      @(negedge clk);

      // ---- R6: youngest writer decides ----
      drain();
      bypass_en = 1'b1;
      drive(C_LD, 1, 2, 5);
      @(negedge clk);
      drive(C_INT, 1, 2, 5);
      @(negedge clk);
      drive(C_INT, 5, 6, 10);
      count_hold(cnt);
      chk("R6 youngest stall", cnt, 0);
      chk("R6 youngest fwd_a", int'(fwd_a), 2);
      @(negedge clk);

      // ---- R7: store writes nothing ----
      drain();
      drive(C_ST, 1, 2, 5);
      @(negedge clk);
      drive(C_FP, 5, 6, 10);
      count_hold(cnt);
      chk("R7 store no dest stall", cnt, 0);
      chk("R7 store no dest fwd_a", int'(fwd_a), 0);
      @(negedge clk);

      // ---- R7: load ignores src_b ----
      drain();
      drive(C_LD, 1, 2, 5);
      @(negedge clk);
      drive(C_LD, 6, 5, 10);
      count_hold(cnt);
      chk("R7 load src_b stall", cnt, 0);
      chk("R7 load src_b fwd_b", int'(fwd_b), 0);
      @(negedge clk);

      // ---- R10: consumer swapped mid-hold, total hold still bounded ----
      drain();
      bypass_en = 1'b0;
      drive(C_LD, 1, 2, 5);
      @(negedge clk);
      drive(C_INT, 5, 6, 10);
      cnt = 0;
      #1;
      for (int k = 0; k < 2; k++) begin
         if (stall) cnt++;
         @(negedge clk);
         #1;
      end
      drive(C_FP, 6, 5, 11);
      #1;
      while (stall && cnt < 20) begin
         cnt++;
         @(negedge clk);
         #1;
      end
      chk("R10 swapped consumer hold", cnt, 5);
      @(negedge clk);
      in_valid = 1'b0;

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule